// File: doc/BRIEF.md
# RTC Register and Interrupt Interface

This block is the software-visible register bank of a real-time clock. A host reaches it through simple 32-bit read and write strobes with a byte address. The bank holds the values that software programs for the time keeper: the time to load, the calibration word, the alarm, the control word and a safety-check scratch word. It drives these values out on plain ports. The live values from the time keeper come in on plain ports and are read back through the bank: current seconds, current sub-second tick, the latched load time and the active calibration.

There are two level interrupts. The first has two sources, a seconds tick (bit 0) and an alarm match (bit 1). The second has one source, an access to an address with no register behind it. Each interrupt has its own write-one-to-clear status word and its own mask. Software cannot write a mask directly. It changes a mask through an enable command word, which clears mask bits, and a disable command word, which sets mask bits. Each interrupt line is high while some status bit is set and its mask bit is clear.

Top module: `rtc_regbank`

## Requirements
- R1: Writing the RTC status word (byte 0x1C) clears each status bit whose data bit is 1 and leaves each bit whose data bit is 0 unchanged.
- R2: After reset the RTC mask (0x20) reads 0x3, the error mask (0x30) reads 0x1, all status bits are 0 and both interrupts are low.
- R3: A write to the RTC enable word (0x24) clears the mask bits where data[1:0] is 1. The word reads as 0.
- R4: A write to the RTC disable word (0x28) sets the mask bits where data[1:0] is 1. The word reads as 0.
- R5: A direct write to either mask word leaves the mask unchanged and raises no error.
- R6: irq_rtc is high exactly when some RTC status bit is 1 while its mask bit is 0. It changes only in the cycle after an event or a write.
- R7: The error interrupt works in the same way on bit 0: status at 0x2C, mask at 0x30, enable at 0x34 and disable at 0x38. It drives irq_aerr.
- R8: A one-cycle pulse on evt_tick sets RTC status bit 0, and a pulse on evt_alarm sets bit 1. When a pulse arrives in the same cycle as a clearing write to that bit, the bit stays set.
- R9: A read or write to an unaligned address, or to any word outside the map (0x00–0x38, 0x40, 0x50), sets the error status bit. Such a read returns 0.
- R10: Control (0x40) resets to 0x0100_0000. Only bits 31, 27:24 and 0 accept writes. All other bits keep their reset value.
- R11: These words are read-only: 0x04 returns settime_now_i, 0x0C returns calib_now_i zero-extended from 21 bits, 0x10 returns time_now_i, and 0x14 returns tick_now_i zero-extended from 16 bits. Writes to them have no effect and raise no error.
- R12: The words at 0x00, 0x08, 0x18 and 0x50 store all 32 written bits. They read back and drive settime_o, calib_o, alarm_o and safety_o. All reset to 0.
- R13: Read data appears on rdata in the cycle after rd_en and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| evt_tick | input | 1 | Seconds-tick event pulse |
| evt_alarm | input | 1 | Alarm-match event pulse |
| time_now_i | input | 32 | Current seconds count |
| tick_now_i | input | 16 | Current sub-second tick |
| calib_now_i | input | 21 | Active calibration value |
| settime_now_i | input | 32 | Latched load time |
| settime_o | output | 32 | Programmed load time |
| calib_o | output | 32 | Programmed calibration |
| alarm_o | output | 32 | Programmed alarm |
| ctrl_o | output | 32 | Control word |
| safety_o | output | 32 | Safety-check word |
| irq_rtc | output | 1 | RTC interrupt |
| irq_aerr | output | 1 | Address-error interrupt |

## Verification
Assertions check on every cycle that the masks return to all-ones after reset and move only on command writes. They also check that an event always leaves its status bit set, that no status bit rises without an event, that irq_rtc never moves without an event or a write, that a bad read returns zero, and that the reserved control bits never change. The bench scenarios are needed to show the rest. Those cover the exact bit-by-bit effect of the clear, enable and disable commands, the event-over-clear priority, which offsets count as unmapped, the read-only returns, and the stored values. A random mix of accesses and events is compared against a bench model of the map.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int          DW        = 32;
    localparam int          RTC_SRC   = 2;
    localparam int          AERR_SRC  = 1;
    localparam int          CAL_W     = 21;
    localparam int          TICK_W    = 16;
    localparam logic [31:0] CTRL_RST  = 32'h0100_0000;
    localparam logic [31:0] CTRL_RSVD = 32'h70FF_FFFE;

    typedef enum logic [4:0] {
        SEL_NONE,
        SEL_SET_WR, SEL_SET_RD, SEL_CAL_WR, SEL_CAL_RD,
        SEL_TIME, SEL_TICK, SEL_ALARM,
        SEL_ISTAT, SEL_IMASK, SEL_IEN, SEL_IDIS,
        SEL_ESTAT, SEL_EMASK, SEL_EEN, SEL_EDIS,
        SEL_CTRL, SEL_SAFE
    } reg_sel_e;

    typedef struct packed {
        logic        wr;
        logic        rd;
        reg_sel_e    sel;
        logic [31:0] data;
    } bus_req_t;

    function automatic reg_sel_e word_to_sel(input logic [5:0] w);
        case (w)
            6'd0:    return SEL_SET_WR;
            6'd1:    return SEL_SET_RD;
            6'd2:    return SEL_CAL_WR;
            6'd3:    return SEL_CAL_RD;
            6'd4:    return SEL_TIME;
            6'd5:    return SEL_TICK;
            6'd6:    return SEL_ALARM;
            6'd7:    return SEL_ISTAT;
            6'd8:    return SEL_IMASK;
            6'd9:    return SEL_IEN;
            6'd10:   return SEL_IDIS;
            6'd11:   return SEL_ESTAT;
            6'd12:   return SEL_EMASK;
            6'd13:   return SEL_EEN;
            6'd14:   return SEL_EDIS;
            6'd16:   return SEL_CTRL;
            6'd20:   return SEL_SAFE;
            default: return SEL_NONE;
        endcase
    endfunction

    function automatic logic [31:0] ctrl_merge(input logic [31:0] old_v,
                                               input logic [31:0] new_v);
        return (old_v & CTRL_RSVD) | (new_v & ~CTRL_RSVD);
    endfunction

endpackage

// File: rtl/rtc_addr_dec.sv
module rtc_addr_dec
    import rtc_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wdata,
    output bus_req_t          req,
    output logic              bad_acc
);
    logic     aligned;
    logic     in_window;
    reg_sel_e sel;

    assign aligned   = (addr[1:0] == 2'b00);
    assign in_window = ((addr >> 8) == '0);
    assign sel       = (aligned && in_window) ? word_to_sel(addr[7:2]) : SEL_NONE;

    always_comb begin
        req.wr   = wr_en;
        req.rd   = rd_en;
        req.sel  = sel;
        req.data = wdata;
    end

    assign bad_acc = (wr_en || rd_en) && (sel == SEL_NONE);
endmodule

// File: rtl/rtc_irq_ctl.sv
module rtc_irq_ctl #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] evt,
    input  logic         clr_wr,
    input  logic         en_wr,
    input  logic         dis_wr,
    input  logic [N-1:0] wd,
    output logic [N-1:0] status,
    output logic [N-1:0] mask,
    output logic         irq
);
    logic [N-1:0] clr_bits;

    assign clr_bits = clr_wr ? wd : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            status <= '0;
            mask   <= '1;
        end else begin
            status <= (status & ~clr_bits) | evt;
            if (en_wr)
                mask <= mask & ~wd;
            else if (dis_wr)
                mask <= mask | wd;
        end
    end

    assign irq = |(status & ~mask);

    AST_MASK_AFTER_RST: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (mask == {N{1'b1}}));                          // R2
    AST_MASK_ONLY_CMD: assert property (@(posedge clk) disable iff (rst)
        !(en_wr || dis_wr) |=> (mask == $past(mask)));                // R5
    AST_EVT_SETS: assert property (@(posedge clk) disable iff (rst)
        (|evt) |=> ((status & $past(evt)) == $past(evt)));            // R8
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((status & ~$past(status) & ~$past(evt)) == '0));     // R8
endmodule

// File: rtl/rtc_store.sv
module rtc_store
    import rtc_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  bus_req_t      req,
    output logic [DW-1:0] settime_o,
    output logic [DW-1:0] calib_o,
    output logic [DW-1:0] alarm_o,
    output logic [DW-1:0] ctrl_o,
    output logic [DW-1:0] safety_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            settime_o <= '0;
            calib_o   <= '0;
            alarm_o   <= '0;
            ctrl_o    <= CTRL_RST;
            safety_o  <= '0;
        end else if (req.wr) begin
            case (req.sel)
                SEL_SET_WR: settime_o <= req.data;
                SEL_CAL_WR: calib_o   <= req.data;
                SEL_ALARM:  alarm_o   <= req.data;
                SEL_CTRL:   ctrl_o    <= ctrl_merge(ctrl_o, req.data);
                SEL_SAFE:   safety_o  <= req.data;
                default: ;
            endcase
        end
    end

    AST_CTRL_RSVD: assert property (@(posedge clk) disable iff (rst)
        (ctrl_o & CTRL_RSVD) == (CTRL_RST & CTRL_RSVD));               // R10
endmodule

// File: rtl/rtc_regbank.sv
module rtc_regbank
    import rtc_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    input  logic              evt_tick,
    input  logic              evt_alarm,
    input  logic [31:0]       time_now_i,
    input  logic [15:0]       tick_now_i,
    input  logic [20:0]       calib_now_i,
    input  logic [31:0]       settime_now_i,
    output logic [31:0]       settime_o,
    output logic [31:0]       calib_o,
    output logic [31:0]       alarm_o,
    output logic [31:0]       ctrl_o,
    output logic [31:0]       safety_o,
    output logic              irq_rtc,
    output logic              irq_aerr
);
    bus_req_t            req;
    logic                bad_acc;
    logic [RTC_SRC-1:0]  rtc_stat, rtc_mask;
    logic [AERR_SRC-1:0] err_stat, err_mask;
    logic [DW-1:0]       rd_mux;

    rtc_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
        .req(req), .bad_acc(bad_acc)
    );

    rtc_irq_ctl #(.N(RTC_SRC)) u_rtc_irq (
        .clk(clk), .rst(rst),
        .evt({evt_alarm, evt_tick}),
        .clr_wr(req.wr && req.sel == SEL_ISTAT),
        .en_wr (req.wr && req.sel == SEL_IEN),
        .dis_wr(req.wr && req.sel == SEL_IDIS),
        .wd(req.data[RTC_SRC-1:0]),
        .status(rtc_stat), .mask(rtc_mask), .irq(irq_rtc)
    );

    rtc_irq_ctl #(.N(AERR_SRC)) u_err_irq (
        .clk(clk), .rst(rst),
        .evt(bad_acc),
        .clr_wr(req.wr && req.sel == SEL_ESTAT),
        .en_wr (req.wr && req.sel == SEL_EEN),
        .dis_wr(req.wr && req.sel == SEL_EDIS),
        .wd(req.data[AERR_SRC-1:0]),
        .status(err_stat), .mask(err_mask), .irq(irq_aerr)
    );

    rtc_store u_store (
        .clk(clk), .rst(rst), .req(req),
        .settime_o(settime_o), .calib_o(calib_o), .alarm_o(alarm_o),
        .ctrl_o(ctrl_o), .safety_o(safety_o)
    );

    always_comb begin
        rd_mux = '0;
        case (req.sel)
            SEL_SET_WR: rd_mux = settime_o;
            SEL_SET_RD: rd_mux = settime_now_i;
            SEL_CAL_WR: rd_mux = calib_o;
            SEL_CAL_RD: rd_mux = DW'(calib_now_i);
            SEL_TIME:   rd_mux = time_now_i;
            SEL_TICK:   rd_mux = DW'(tick_now_i);
            SEL_ALARM:  rd_mux = alarm_o;
            SEL_ISTAT:  rd_mux = DW'(rtc_stat);
            SEL_IMASK:  rd_mux = DW'(rtc_mask);
            SEL_ESTAT:  rd_mux = DW'(err_stat);
            SEL_EMASK:  rd_mux = DW'(err_mask);
            SEL_CTRL:   rd_mux = ctrl_o;
            SEL_SAFE:   rd_mux = safety_o;
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata <= '0;
        else if (rd_en)
            rdata <= rd_mux;
    end

    AST_BAD_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_en && bad_acc) |=> (rdata == '0));                        // R9
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rdata));                                   // R13
    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!evt_tick && !evt_alarm && !wr_en) |=> $stable(irq_rtc));    // R6
endmodule

// File: tb/test_rtc_regbank.sv
module test_rtc_regbank;
    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en, rd_en, evt_tick, evt_alarm;
    logic [7:0]  addr;
    logic [31:0] wdata, rdata;
    logic [31:0] time_now_i, settime_now_i;
    logic [15:0] tick_now_i;
    logic [20:0] calib_now_i;
    logic [31:0] settime_o, calib_o, alarm_o, ctrl_o, safety_o;
    logic        irq_rtc, irq_aerr;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // bench model
    logic [1:0]  m_stat, m_mask;
    logic        e_stat, e_mask;
    logic [31:0] m_set, m_cal, m_alm, m_ctl, m_saf;

    always #4 clk = ~clk;

    rtc_regbank #(.ADDR_W(8)) i_rtc_regbank (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .evt_tick(evt_tick), .evt_alarm(evt_alarm),
        .time_now_i(time_now_i), .tick_now_i(tick_now_i), .calib_now_i(calib_now_i),
        .settime_now_i(settime_now_i), .settime_o(settime_o), .calib_o(calib_o),
        .alarm_o(alarm_o), .ctrl_o(ctrl_o), .safety_o(safety_o),
        .irq_rtc(irq_rtc), .irq_aerr(irq_aerr)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit mapped(input logic [7:0] a);
        return (a[1:0] == 2'b00) && (a <= 8'h38 || a == 8'h40 || a == 8'h50);
    endfunction

    function automatic logic [31:0] exp_read(input logic [7:0] a);
        if (!mapped(a)) return 32'h0;
        case (a)
            8'h00: return m_set;
            8'h04: return settime_now_i;
            8'h08: return m_cal;
            8'h0C: return {11'h0, calib_now_i};
            8'h10: return time_now_i;
            8'h14: return {16'h0, tick_now_i};
            8'h18: return m_alm;
            8'h1C: return {30'h0, m_stat};
            8'h20: return {30'h0, m_mask};
            8'h2C: return {31'h0, e_stat};
            8'h30: return {31'h0, e_mask};
            8'h40: return m_ctl;
            8'h50: return m_saf;
            default: return 32'h0;
        endcase
    endfunction

    task automatic model_reset();
        m_stat = 2'b00; m_mask = 2'b11; e_stat = 1'b0; e_mask = 1'b1;
        m_set = '0; m_cal = '0; m_alm = '0; m_ctl = 32'h0100_0000; m_saf = '0;
    endtask

    task automatic model_update(input logic w, input logic r, input logic [7:0] a,
                                input logic [31:0] d, input logic [1:0] ev);
        logic [1:0] clr = 2'b00;
        logic       eclr = 1'b0;
        if (w && mapped(a)) begin
            case (a)
                8'h00: m_set = d;
                8'h08: m_cal = d;
                8'h18: m_alm = d;
                8'h1C: clr = d[1:0];
                8'h24: m_mask = m_mask & ~d[1:0];
                8'h28: m_mask = m_mask | d[1:0];
                8'h2C: eclr = d[0];
                8'h34: e_mask = e_mask & ~d[0];
                8'h38: e_mask = e_mask | d[0];
                8'h40: m_ctl = (m_ctl & 32'h70FF_FFFE) | (d & 32'h8F00_0001);
                8'h50: m_saf = d;
                default: ;
            endcase
        end
        m_stat = (m_stat & ~clr) | ev;
        e_stat = (e_stat & ~eclr) | ((w || r) && !mapped(a));
    endtask

    // drive at negedge, update model at posedge, check at next negedge
    task automatic step(input string tag, input logic w, input logic r,
                        input logic [7:0] a, input logic [31:0] d, input logic [1:0] ev);
        logic [31:0] er;
        wr_en = w; rd_en = r; addr = a; wdata = d;
        evt_tick = ev[0]; evt_alarm = ev[1];
        er = exp_read(a);
        @(posedge clk);
        model_update(w, r, a, d, ev);
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0; evt_tick = 1'b0; evt_alarm = 1'b0;
        if (r) check(tag, rdata, er);
        check({tag, " R6 irq_rtc"}, {31'h0, irq_rtc}, {31'h0, |(m_stat & ~m_mask)});
        check({tag, " R7 irq_aerr"}, {31'h0, irq_aerr}, {31'h0, e_stat & ~e_mask});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1; wr_en = 0; rd_en = 0; addr = 0; wdata = 0;
        evt_tick = 0; evt_alarm = 0;
        time_now_i = 32'h1234_5678; tick_now_i = 16'hBEEF;
        calib_now_i = 21'h1A_BCDE; settime_now_i = 32'hCAFE_0001;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R2 reset state
        check("R2 irq_rtc reset", {31'h0, irq_rtc}, 32'h0);
        check("R2 irq_aerr reset", {31'h0, irq_aerr}, 32'h0);
        step("R2 mask read", 0, 1, 8'h20, 0, 2'b00);
        step("R2 emask read", 0, 1, 8'h30, 0, 2'b00);
        step("R10 ctrl reset", 0, 1, 8'h40, 0, 2'b00);
        step("R12 safety reset", 0, 1, 8'h50, 0, 2'b00);
        check("R12 safety_o reset", safety_o, 32'h0);

        // R8 events while masked, R3 enable
        step("R8 tick event", 0, 0, 8'h00, 0, 2'b01);
        step("R8 status read", 0, 1, 8'h1C, 0, 2'b00);
        step("R3 enable bit0", 1, 0, 8'h24, 32'h1, 2'b00);
        check("R3 irq up", {31'h0, irq_rtc}, 32'h1);
        step("R3 enable reads 0", 0, 1, 8'h24, 0, 2'b00);
        step("R3 mask after enable", 0, 1, 8'h20, 0, 2'b00);
        // R1 w1c with 0 no effect, then clear
        step("R1 write zero", 1, 0, 8'h1C, 32'h0, 2'b00);
        step("R1 status kept", 0, 1, 8'h1C, 0, 2'b00);
        step("R1 clear", 1, 0, 8'h1C, 32'h1, 2'b00);
        check("R1 irq dropped", {31'h0, irq_rtc}, 32'h0);
        // R8 event vs clear same cycle
        step("R8 alarm", 0, 0, 8'h00, 0, 2'b10);
        step("R8 clear vs event", 1, 0, 8'h1C, 32'h3, 2'b10);
        step("R8 event wins", 0, 1, 8'h1C, 0, 2'b00);
        // R4 disable
        step("R4 disable", 1, 0, 8'h28, 32'hFFFF_FFFF, 2'b00);
        step("R4 disable reads 0", 0, 1, 8'h28, 0, 2'b00);
        step("R4 mask all", 0, 1, 8'h20, 0, 2'b00);
        // R5 direct mask writes ignored
        step("R5 mask write", 1, 0, 8'h20, 32'h0, 2'b00);
        step("R5 mask kept", 0, 1, 8'h20, 0, 2'b00);
        step("R5 emask write", 1, 0, 8'h30, 32'h0, 2'b00);
        step("R5 emask kept", 0, 1, 8'h30, 0, 2'b00);
        // R9 / R7 address error
        step("R7 enable err", 1, 0, 8'h34, 32'h1, 2'b00);
        step("R9 gap read", 0, 1, 8'h3C, 0, 2'b00);
        check("R9 irq_aerr set", {31'h0, irq_aerr}, 32'h1);
        step("R9 unaligned read", 0, 1, 8'h01, 0, 2'b00);
        step("R7 err status", 0, 1, 8'h2C, 0, 2'b00);
        step("R7 err clear", 1, 0, 8'h2C, 32'h1, 2'b00);
        step("R9 hi write", 1, 0, 8'hFC, 32'h5, 2'b00);
        step("R7 err disable", 1, 0, 8'h38, 32'h1, 2'b00);
        // R10 control
        step("R10 ctrl write", 1, 0, 8'h40, 32'hFFFF_FFFF, 2'b00);
        step("R10 ctrl all", 0, 1, 8'h40, 0, 2'b00);
        step("R10 ctrl write0", 1, 0, 8'h40, 32'h0, 2'b00);
        check("R10 ctrl_o", ctrl_o, 32'h0000_0000 | (32'h0100_0000 & 32'h70FF_FFFE));
        // R11 read-only
        step("R11 ro write", 1, 0, 8'h10, 32'h0, 2'b00);
        step("R11 time", 0, 1, 8'h10, 0, 2'b00);
        step("R11 tick", 0, 1, 8'h14, 0, 2'b00);
        step("R11 calib", 0, 1, 8'h0C, 0, 2'b00);
        step("R11 settime", 0, 1, 8'h04, 0, 2'b00);
        // R12 stored words
        step("R12 alarm write", 1, 0, 8'h18, 32'hA5A5_0F0F, 2'b00);
        check("R12 alarm_o", alarm_o, 32'hA5A5_0F0F);
        step("R12 alarm read", 0, 1, 8'h18, 0, 2'b00);
        // R13 hold
        step("R13 idle", 0, 0, 8'h18, 0, 2'b00);
        check("R13 rdata hold", rdata, 32'hA5A5_0F0F);

        // random mix
        for (int i = 0; i < 3000; i++) begin
            logic [7:0]  a;
            logic [31:0] d;
            logic [1:0]  ev;
            logic        w, r;
            int          k;
            k = $urandom_range(0, 99);
            a = (k < 5) ? 8'($urandom_range(0, 255)) : 8'($urandom_range(0, 21) * 4);
            d = $urandom();
            ev = ($urandom_range(0, 9) == 0) ? 2'($urandom_range(1, 3)) : 2'b00;
            r = ($urandom_range(0, 1) == 1);
            w = !r && ($urandom_range(0, 2) != 0);
            step("R13 random", w, r, a, d, ev);
            if (i % 50 == 0) begin
                check("R12 settime_o", settime_o, m_set);
                check("R12 calib_o", calib_o, m_cal);
                check("R10 ctrl_o rand", ctrl_o, m_ctl);
                check("R12 safety_o", safety_o, m_saf);
            end
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule